// File: doc/BRIEF.md
# AXI DDR Address Segmentation Unit

This block sits on the path from a processor-side AXI master to a DDR controller. Every channel passes straight through except the write and read address channels. On those channels the top bits of each address select one of seven fixed memory windows. The signed offset held for that window, scaled to 16 MiB granules, is then added to the address so that the request lands at a base of software's choosing in physical DDR. An address outside every window leaves the block unchanged.

The offsets live in a small register bank on a simple single-cycle register bus. The bank is split into two groups at a stride of 64 words. Group 0 implements two segment registers and group 1 implements five. Each segment register carries a lock bit that freezes it until reset. A word in group 0 holds a write blocker. From reset until software sets its release bit, the blocker holds every DDR write at the AW and W handshakes. The release is sticky and only a reset clears it. Reads are never held.

Top module: `axi_ddr_seg`

## Requirements
- R1: For a matched window, the outgoing address equals the incoming address plus the window's 15-bit two's-complement offset placed at address bits [38:24] and sign-extended to bit 39. The sum is taken modulo 2^40.
- R2: The window is picked by incoming address bits [39:36]. A value v from 1 to 7 selects segment v-1. Values 0 and 8 to 15 pass the address through unmodified.
- R3: Segment registers sit at register word address {group, 3'b000, slot}, where group is bit 6 and slot is bits [2:0]. Segments 0 and 1 are group 0 slots 0 and 1. Segments 2 to 6 are group 1 slots 0 to 4. A register holds the offset in bits [14:0] and the lock in bit 31. Bits [30:15] read as zero whatever was written.
- R4: While a segment register's lock bit is 1, writes to that register change neither its offset nor its lock.
- R5: Unimplemented slots read as zero and writes to them have no effect. These are group 0 slots 2 to 6, group 1 slots 5 to 7, and any address with bits [5:3] nonzero.
- R6: While the blocker is not released, m_awvalid, s_awready, m_wvalid and s_wready are 0. Once it is released, these four follow their counterpart inputs.
- R7: The blocker release is bit 7 of group 0 slot 7, which reads back with the release state in bit 7 and zeros elsewhere. Writing 1 sets the release. Writing 0 does not clear it, and only reset does.
- R8: The read address channel is never held. m_arvalid follows s_arvalid and s_arready follows m_arready whatever the blocker state.
- R9: W data and last, B response and R data, response and last pass through unchanged.
- R10: After reset, every offset and lock is zero and the blocker is not released.
- R11: reg_rdata is updated on the clock edge at which reg_rd is sampled high, and holds its value while reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awaddr | input | 40 | Upstream write address |
| m_awvalid | output | 1 | DDR-side write address valid |
| m_awready | input | 1 | DDR-side write address ready |
| m_awaddr | output | 40 | Rewritten write address |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | 64 | Upstream write data |
| s_wlast | input | 1 | Upstream last beat |
| m_wvalid | output | 1 | DDR-side write data valid |
| m_wready | input | 1 | DDR-side write data ready |
| m_wdata | output | 64 | DDR-side write data |
| m_wlast | output | 1 | DDR-side last beat |
| m_bvalid | input | 1 | DDR-side write response valid |
| m_bready | output | 1 | DDR-side write response ready |
| m_bresp | input | 2 | DDR-side write response |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bresp | output | 2 | Upstream write response |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_araddr | input | 40 | Upstream read address |
| m_arvalid | output | 1 | DDR-side read address valid |
| m_arready | input | 1 | DDR-side read address ready |
| m_araddr | output | 40 | Rewritten read address |
| m_rvalid | input | 1 | DDR-side read data valid |
| m_rready | output | 1 | DDR-side read data ready |
| m_rdata | input | 64 | DDR-side read data |
| m_rresp | input | 2 | DDR-side read response |
| m_rlast | input | 1 | DDR-side read last |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rdata | output | 64 | Upstream read data |
| s_rresp | output | 2 | Upstream read response |
| s_rlast | output | 1 | Upstream read last |

## Verification
The blocker and the read path can act in the same cycle. A held write and a live read then meet: the write address and data handshakes must stay closed while the read address flows through already translated. The bench drives valid and ready on both address channels and on W while the blocker is still engaged. It checks at the ports that the write side stays gated and the read side passes with the expected rewritten address. Then it releases the blocker with those inputs still applied and checks that the write handshakes open at once.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_OFF_W    = 15;
  localparam int SEG_LOCK_BIT = 31;
  localparam int SEG_REG_W    = 32;

  typedef struct packed {
    logic                 lock;
    logic [SEG_OFF_W-1:0] off;
  } seg_entry_t;
endpackage

// File: rtl/seg_regbank.sv
module seg_regbank
  import seg_pkg::*;
#(
  parameter int SLOT_W   = 3,
  parameter int STRIDE_W = 6,
  parameter int G0_IMPL  = 2,
  parameter int G1_IMPL  = 5,
  parameter int CFG_SLOT = 7,
  parameter int BLK_BIT  = 7,
  localparam int REG_AW  = STRIDE_W + 1,
  localparam int NREG    = G0_IMPL + G1_IMPL
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [SEG_REG_W-1:0]      reg_wdata,
  output logic [SEG_REG_W-1:0]      reg_rdata,
  output logic [NREG*SEG_OFF_W-1:0] off_flat,
  output logic                      blk_off
);
  localparam int FILL_W = STRIDE_W - SLOT_W;

  logic                 grp;
  logic [FILL_W-1:0]    fill;
  logic [SLOT_W-1:0]    slot;
  logic                 impl_hit;
  logic                 cfg_hit;
  logic [NREG-1:0]      sel_vec;
  logic [SEG_REG_W-1:0] rd_word;
  seg_entry_t           ent_q [NREG];

  always_comb begin
    grp      = reg_addr[REG_AW-1];
    fill     = reg_addr[STRIDE_W-1:SLOT_W];
    slot     = reg_addr[SLOT_W-1:0];
    impl_hit = (fill == '0) &&
               (grp ? (int'(slot) < G1_IMPL) : (int'(slot) < G0_IMPL));
    cfg_hit  = !grp && (fill == '0) && (int'(slot) == CFG_SLOT);
    for (int i = 0; i < NREG; i++) begin
      sel_vec[i] = impl_hit &&
                   ((grp ? (G0_IMPL + int'(slot)) : int'(slot)) == i);
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q[i] <= '0;
      end else if (reg_wr && sel_vec[i] && !ent_q[i].lock) begin
        ent_q[i].off  <= reg_wdata[SEG_OFF_W-1:0];
        ent_q[i].lock <= reg_wdata[SEG_LOCK_BIT];
      end
    end
    assign off_flat[i*SEG_OFF_W +: SEG_OFF_W] = ent_q[i].off;

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
      ent_q[i].lock |=> (ent_q[i].lock && $stable(ent_q[i].off))); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_off <= 1'b0;
    end else if (reg_wr && cfg_hit && reg_wdata[BLK_BIT]) begin
      blk_off <= 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel_vec[i]) begin
        rd_word[SEG_OFF_W-1:0] = ent_q[i].off;
        rd_word[SEG_LOCK_BIT]  = ent_q[i].lock;
      end
    end
    if (cfg_hit) rd_word[BLK_BIT] = blk_off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_word;
    end
  end

  AST_BLK_STICKY: assert property (@(posedge clk) disable iff (rst)
    blk_off |=> blk_off); // R7
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !impl_hit && !cfg_hit) |=> (reg_rdata == '0)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && impl_hit) |=> (reg_rdata[SEG_LOCK_BIT-1:SEG_OFF_W] == '0)); // R3
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ADDR_W  = 40,
  parameter int SEL_LSB = 36,
  parameter int OFF_W   = 15,
  parameter int OFF_LSB = 24,
  parameter int NREG    = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NREG*OFF_W-1:0]  off_flat,
  output logic [ADDR_W-1:0]      addr_o
);
  localparam int SEL_W = ADDR_W - SEL_LSB;
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [SEL_W-1:0]  sel;
  logic              hit;
  logic [OFF_W-1:0]  off_sel;
  logic [ADDR_W-1:0] delta;

  always_comb begin
    sel     = addr_i[ADDR_W-1:SEL_LSB];
    hit     = 1'b0;
    off_sel = '0;
    for (int r = 0; r < NREG; r++) begin
      if (sel == SEL_W'(r + 1)) begin
        hit     = 1'b1;
        off_sel = off_flat[r*OFF_W +: OFF_W];
      end
    end
    delta  = {{EXT_W{off_sel[OFF_W-1]}}, off_sel} << OFF_LSB;
    addr_o = hit ? (addr_i + delta) : addr_i;
  end

  AST_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    ((addr_i[ADDR_W-1:SEL_LSB] == '0) || (int'(addr_i[ADDR_W-1:SEL_LSB]) > NREG))
      |-> (addr_o == addr_i)); // R2
  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    addr_o[OFF_LSB-1:0] == addr_i[OFF_LSB-1:0]); // R1
endmodule

// File: rtl/axi_ddr_seg.sv
module axi_ddr_seg
  import seg_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int DATA_W   = 64,
  parameter int SEL_LSB  = 36,
  parameter int OFF_LSB  = 24,
  parameter int SLOT_W   = 3,
  parameter int STRIDE_W = 6,
  parameter int G0_IMPL  = 2,
  parameter int G1_IMPL  = 5,
  parameter int CFG_SLOT = 7,
  parameter int BLK_BIT  = 7,
  localparam int REG_AW  = STRIDE_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [SEG_REG_W-1:0] reg_wdata,
  output logic [SEG_REG_W-1:0] reg_rdata,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [ADDR_W-1:0]    s_awaddr,
  output logic                 m_awvalid,
  input  logic                 m_awready,
  output logic [ADDR_W-1:0]    m_awaddr,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  input  logic [DATA_W-1:0]    s_wdata,
  input  logic                 s_wlast,
  output logic                 m_wvalid,
  input  logic                 m_wready,
  output logic [DATA_W-1:0]    m_wdata,
  output logic                 m_wlast,
  input  logic                 m_bvalid,
  output logic                 m_bready,
  input  logic [1:0]           m_bresp,
  output logic                 s_bvalid,
  input  logic                 s_bready,
  output logic [1:0]           s_bresp,
  input  logic                 s_arvalid,
  output logic                 s_arready,
  input  logic [ADDR_W-1:0]    s_araddr,
  output logic                 m_arvalid,
  input  logic                 m_arready,
  output logic [ADDR_W-1:0]    m_araddr,
  input  logic                 m_rvalid,
  output logic                 m_rready,
  input  logic [DATA_W-1:0]    m_rdata,
  input  logic [1:0]           m_rresp,
  input  logic                 m_rlast,
  output logic                 s_rvalid,
  input  logic                 s_rready,
  output logic [DATA_W-1:0]    s_rdata,
  output logic [1:0]           s_rresp,
  output logic                 s_rlast
);
  localparam int NREG  = G0_IMPL + G1_IMPL;
  localparam int NCHAN = 2;

  logic [NREG*SEG_OFF_W-1:0] off_flat;
  logic                      blk_off;
  logic [ADDR_W-1:0]         chan_in  [NCHAN];
  logic [ADDR_W-1:0]         chan_out [NCHAN];

  seg_regbank #(
    .SLOT_W(SLOT_W), .STRIDE_W(STRIDE_W), .G0_IMPL(G0_IMPL),
    .G1_IMPL(G1_IMPL), .CFG_SLOT(CFG_SLOT), .BLK_BIT(BLK_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .off_flat(off_flat), .blk_off(blk_off)
  );

  assign chan_in[0] = s_awaddr;
  assign chan_in[1] = s_araddr;

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    seg_xlate #(
      .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .OFF_W(SEG_OFF_W),
      .OFF_LSB(OFF_LSB), .NREG(NREG)
    ) u_xlate (
      .clk(clk), .rst(rst), .addr_i(chan_in[c]),
      .off_flat(off_flat), .addr_o(chan_out[c])
    );
  end

  assign m_awaddr  = chan_out[0];
  assign m_araddr  = chan_out[1];

  assign m_awvalid = s_awvalid & blk_off;
  assign s_awready = m_awready & blk_off;
  assign m_wvalid  = s_wvalid  & blk_off;
  assign s_wready  = m_wready  & blk_off;
  assign m_wdata   = s_wdata;
  assign m_wlast   = s_wlast;

  assign s_bvalid  = m_bvalid;
  assign m_bready  = s_bready;
  assign s_bresp   = m_bresp;

  assign m_arvalid = s_arvalid;
  assign s_arready = m_arready;

  assign s_rvalid  = m_rvalid;
  assign m_rready  = s_rready;
  assign s_rdata   = m_rdata;
  assign s_rresp   = m_rresp;
  assign s_rlast   = m_rlast;

  AST_BLOCK_AW: assert property (@(posedge clk) disable iff (rst)
    !blk_off |-> (!m_awvalid && !s_awready && !m_wvalid && !s_wready)); // R6
  AST_AR_OPEN: assert property (@(posedge clk) disable iff (rst)
    s_arvalid |-> m_arvalid); // R8
endmodule

// File: tb/axi_ddr_seg_tb.sv
module axi_ddr_seg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic s_awvalid = 0, s_awready, m_awvalid, m_awready = 0;
  logic [AW-1:0] s_awaddr = '0, m_awaddr, s_araddr = '0, m_araddr;
  logic s_wvalid = 0, s_wready, m_wvalid, m_wready = 0, s_wlast = 0, m_wlast;
  logic [DW-1:0] s_wdata = '0, m_wdata, m_rdata = '0, s_rdata;
  logic m_bvalid = 0, m_bready, s_bvalid, s_bready = 0;
  logic [1:0] m_bresp = '0, s_bresp, m_rresp = '0, s_rresp;
  logic s_arvalid = 0, s_arready, m_arvalid, m_arready = 0;
  logic m_rvalid = 0, m_rready, s_rvalid, s_rready = 0, m_rlast = 0, s_rlast;

  int n_chk = 0, n_bad = 0;
  logic [14:0] offs [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_ddr_seg u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  function automatic logic [6:0] seg_addr(input int r);
    return (r < 2) ? 7'(r) : {1'b1, 3'b000, 3'(r - 2)};
  endfunction

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] a);
    int v = int'(a[39:36]);
    logic [AW-1:0] d;
    if (v < 1 || v > 7) return a;
    d = {{25{offs[v-1][14]}}, offs[v-1]};
    d = d << 24;
    return a + d;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic sweep(input string tag);
    logic [35:0] lows [3] = '{36'h0, 36'hF_FFFF_FFFF, 36'h1_2345_6789};
    for (int s = 0; s < 16; s++) begin
      for (int l = 0; l < 3; l++) begin
        @(negedge clk);
        s_awaddr = {4'(s), lows[l]};
        s_araddr = {4'(s), lows[(l + 1) % 3]};
        #1;
        check({tag, " aw"}, 64'(m_awaddr), 64'(expect_addr(s_awaddr)));
        check({tag, " ar"}, 64'(m_araddr), 64'(expect_addr(s_araddr)));
      end
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    offs = '{15'h6FFF, 15'h0123, 15'h4000, 15'h7FFF, 15'h0001, 15'h2AAA, 15'h3FFF};
    do_reset();

    // R10: reset state
    for (int r = 0; r < 7; r++) begin
      reg_read(seg_addr(r), rd);
      check("R10 seg reset", 64'(rd), 64'h0);
    end
    reg_read(7'h07, rd);
    check("R10 blocker reset", 64'(rd), 64'h0);

    // R6/R8: blocked write and live read in the same cycle
    @(negedge clk);
    s_awvalid = 1; m_awready = 1; s_wvalid = 1; m_wready = 1;
    s_arvalid = 1; m_arready = 1;
    s_awaddr = 40'h10_0000_0000; s_araddr = 40'h20_0000_1000;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R6 m_awvalid held", 64'(m_awvalid), 64'h0);
      check("R6 s_awready held", 64'(s_awready), 64'h0);
      check("R6 m_wvalid held", 64'(m_wvalid), 64'h0);
      check("R6 s_wready held", 64'(s_wready), 64'h0);
      check("R8 m_arvalid", 64'(m_arvalid), 64'h1);
      check("R8 s_arready", 64'(s_arready), 64'h1);
    end

    // R3: program offsets with reserved bits set
    for (int r = 0; r < 7; r++) reg_write(seg_addr(r), {1'b0, 16'hFFFF, offs[r]});
    for (int r = 0; r < 7; r++) begin
      reg_read(seg_addr(r), rd);
      check("R3 readback", 64'(rd), 64'({17'h0, offs[r]}));
    end
    @(negedge clk); #1;
    check("R8 ar translated while blocked", 64'(m_araddr), 64'(expect_addr(s_araddr)));
    check("R6 still held", 64'(m_awvalid), 64'h0);

    // R5: unimplemented slots, including a bogus blocker location
    begin
      logic [6:0] bad [10] = '{7'h02, 7'h03, 7'h06, 7'h45, 7'h46, 7'h47,
                               7'h08, 7'h0F, 7'h48, 7'h7F};
      for (int i = 0; i < 10; i++) reg_write(bad[i], 32'hFFFF_FFFF);
      for (int i = 0; i < 10; i++) begin
        reg_read(bad[i], rd);
        check("R5 unimpl reads zero", 64'(rd), 64'h0);
      end
      @(negedge clk); #1;
      check("R5 no blocker release", 64'(m_awvalid), 64'h0);
      for (int r = 0; r < 7; r++) begin
        reg_read(seg_addr(r), rd);
        check("R5 segs untouched", 64'(rd), 64'({17'h0, offs[r]}));
      end
    end

    // R7: release then attempt to clear
    reg_write(7'h07, 32'h0000_0080);
    @(negedge clk); #1;
    check("R6 m_awvalid released", 64'(m_awvalid), 64'h1);
    check("R6 s_awready released", 64'(s_awready), 64'h1);
    check("R6 m_wvalid released", 64'(m_wvalid), 64'h1);
    check("R6 s_wready released", 64'(s_wready), 64'h1);
    reg_write(7'h07, 32'h0);
    reg_read(7'h07, rd);
    check("R7 sticky readback", 64'(rd), 64'h80);
    @(negedge clk); #1;
    check("R7 still open", 64'(m_awvalid), 64'h1);
    m_awready = 0; m_wready = 0; #1;
    check("R6 ready follows", 64'(s_awready), 64'h0);

    // R1/R2: sweep all window selects
    sweep("R1R2");

    // R4: lock segment 1, then try to change it
    reg_write(seg_addr(1), {1'b1, 16'h0, offs[1]});
    reg_write(seg_addr(1), {1'b0, 16'h0, 15'h5555});
    reg_read(seg_addr(1), rd);
    check("R4 locked value", 64'(rd), 64'({1'b1, 16'h0, offs[1]}));
    @(negedge clk); s_awaddr = 40'h20_0ABC_DEF0; #1;
    check("R4 locked xlate", 64'(m_awaddr), 64'(expect_addr(s_awaddr)));

    // R9: passthrough channels
    @(negedge clk);
    s_wdata = 64'hDEAD_BEEF_0123_4567; s_wlast = 1;
    m_bvalid = 1; m_bresp = 2'b10; s_bready = 1;
    m_rvalid = 1; m_rdata = 64'h0F0F_1234_A5A5_9999; m_rresp = 2'b01; m_rlast = 1; s_rready = 1;
    #1;
    check("R9 wdata", m_wdata, 64'hDEAD_BEEF_0123_4567);
    check("R9 wlast", 64'(m_wlast), 64'h1);
    check("R9 b", 64'({s_bvalid, m_bready, s_bresp}), 64'b1110);
    check("R9 r", 64'({s_rvalid, m_rready, s_rresp, s_rlast}), 64'b11011);
    check("R9 rdata", s_rdata, 64'h0F0F_1234_A5A5_9999);

    // R11: rdata holds while reg_rd low
    reg_read(seg_addr(3), rd);
    repeat (2) @(negedge clk);
    check("R11 rdata hold", 64'(reg_rdata), 64'({17'h0, offs[3]}));

    // R10/R7: reset clears release and lock
    m_awready = 1;
    do_reset();
    @(negedge clk); #1;
    check("R7 reset re-blocks", 64'(m_awvalid), 64'h0);
    reg_read(seg_addr(1), rd);
    check("R10 lock cleared", 64'(rd), 64'h0);
    reg_read(7'h07, rd);
    check("R10 blocker cleared", 64'(rd), 64'h0);
    for (int r = 0; r < 7; r++) offs[r] = '0;
    sweep("R10 zero offsets");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule